// File: doc/BRIEF.md
# Page Access Permission and Fault-Code Checker

This block decides whether a memory access may use a page after the page-table walk has finished. It takes the protection flags that the walk has already folded across all levels (no-execute, user, writable), the protection key of the leaf entry, the kind of access and the privilege of the requester. It applies the supervisor-mode rules: write protection of read-only pages, blocking supervisor fetches from user pages, and an optional supervisor mode that may not touch user pages at all. It then applies a per-key filter that can deny all data access or only writes.

The result is one registered response per request. It gives the read, write and execute rights that remain, a single pass bit for the requested access, and a six-bit page-fault error code. Two walk-level faults, missing entry and reserved bit set, arrive as inputs. The checker folds them into the same error-code format, so the fault path downstream sees one word whatever the cause.

Top module: `pgperm_check`

## Requirements
- R1: Every output is registered. `rsp_valid` equals `req_valid` of the previous clock cycle. While `rst` is high, all outputs are cleared to zero on the clock edge.
- R2: A user request (`priv_lvl`=0) to a page with `flag_user`=0 fails with error bit 0 (present) set. All three permission outputs read zero.
- R3: Read is granted unless `priv_lvl`=2 (supervisor barred from user pages) and `flag_user`=1. Write needs read plus either `flag_wr`=1 or a supervisor request (`priv_lvl` 1 or 2) with `mode_wp`=0.
- R4: Execute is granted only when `flag_nx`=0 and at least one of these holds: the request is from user mode, `mode_smep`=0, or `flag_user`=0.
- R5: The key rights come from `ukey_reg` when `flag_user`=1 and `mode_pke`=1, and from `skey_reg` when `flag_user`=0 and `mode_pks`=1. In every other case, and whenever the selected register is zero, the key filter removes nothing.
- R6: For key k (`pte_key`, which is leaf bits 62:59), register bit 2k removes read and write. Bit 2k+1 removes write only, and only for user requests or when `mode_wp`=1. Execute is never removed by a key.
- R7: When the key filter denies the requested access, the error code has bit 5 (key) and bit 0 (present) set. When only the page rules deny it, bit 0 is set and bit 5 is clear.
- R8: `walk_np`=1 gives a fault whose code starts from zero. Otherwise `walk_rsvd`=1 gives a fault with bit 3 (reserved) set. In both cases the permission outputs are zero.
- R9: Every fault code has bit 2 set for user requests, bit 1 set for stores, and bit 4 set for fetches only when `mode_nxe` or `mode_smep` is 1.
- R10: `acc_type` is 0 for load, 1 for store and 2 for fetch. `acc_ok` is the permission output that this code selects (read, write or execute). When `acc_ok`=1, `err_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| priv_lvl | input | 2 | 0 user, 1 supervisor, 2 supervisor barred from user pages |
| flag_nx | input | 1 | Folded no-execute flag |
| flag_user | input | 1 | Folded user-page flag |
| flag_wr | input | 1 | Folded writable flag |
| pte_key | input | 4 | Leaf entry protection key (bits 62:59) |
| mode_wp | input | 1 | Supervisor write protection enable |
| mode_smep | input | 1 | Block supervisor fetch from user pages |
| mode_nxe | input | 1 | No-execute enable |
| mode_pke | input | 1 | Keys enabled for user pages |
| mode_pks | input | 1 | Keys enabled for supervisor pages |
| ukey_reg | input | 32 | Key rights register for user pages |
| skey_reg | input | 32 | Key rights register for supervisor pages |
| walk_np | input | 1 | Walk found a missing entry |
| walk_rsvd | input | 1 | Walk found a reserved bit set |
| rsp_valid | output | 1 | Response valid |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| acc_ok | output | 1 | Requested access allowed |
| err_code | output | 6 | Page-fault error code |

## Verification
The assertions take `acc_type` and `priv_lvl` to carry only the codes 0 to 2. They also take the request fields to be held for the whole cycle in which `req_valid` is high, because the properties look back one cycle to the request that produced a response. The stimulus draws both codes modulo three and changes inputs only on the falling edge. It also makes the key registers zero part of the time, so that the disabled-key path and the active-key path are both exercised.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  // access codes: the value indexes the rights vector {x,w,r}
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] PRIV_USER   = 2'd0;
  localparam logic [1:0] PRIV_SUP    = 2'd1;
  localparam logic [1:0] PRIV_SUP_NU = 2'd2;

  // error-code bit positions
  localparam int EB_P = 0;
  localparam int EB_W = 1;
  localparam int EB_U = 2;
  localparam int EB_R = 3;
  localparam int EB_I = 4;
  localparam int EB_K = 5;
  localparam int ERR_W = 6;

  typedef enum logic [2:0] {
    FK_NONE, FK_NOTPRES, FK_RSVD, FK_PROT, FK_KEY
  } fault_kind_t;
endpackage

// File: rtl/pgperm_rights.sv
module pgperm_rights (
  input  logic       is_user,
  input  logic       no_user_pg,
  input  logic       flag_nx,
  input  logic       flag_user,
  input  logic       flag_wr,
  input  logic       wp,
  input  logic       smep,
  output logic [2:0] prot
);
  logic rd_ok;
  always_comb begin
    rd_ok   = !(no_user_pg && flag_user);
    prot[0] = rd_ok;
    prot[1] = rd_ok && (flag_wr || (!is_user && !wp));
    prot[2] = !flag_nx && (is_user || !smep || !flag_user);
  end
endmodule

// File: rtl/pgperm_keyfilt.sv
module pgperm_keyfilt #(
  parameter int KEY_W = 4,
  parameter int PKR_W = 32
) (
  input  logic             is_user,
  input  logic             wp,
  input  logic             pke,
  input  logic             pks,
  input  logic             flag_user,
  input  logic [KEY_W-1:0] key,
  input  logic [PKR_W-1:0] ukey,
  input  logic [PKR_W-1:0] skey,
  output logic [2:0]       kprot
);
  localparam int IW = $clog2(PKR_W);

  logic [PKR_W-1:0] sel;
  logic [IW-1:0]    ad_idx;
  logic             ad, wd;

  always_comb begin
    if (flag_user) sel = pke ? ukey : '0;
    else           sel = pks ? skey : '0;
    ad_idx = IW'({key, 1'b0});
    ad     = sel[ad_idx];
    wd     = sel[ad_idx + IW'(1)];
    kprot  = 3'b111;
    if (sel != '0) begin
      if (ad)                       kprot[1:0] = 2'b00;
      else if (wd && (is_user || wp)) kprot[1] = 1'b0;
    end
  end
endmodule

// File: rtl/pgperm_ecode.sv
module pgperm_ecode
  import pgperm_pkg::*;
(
  input  fault_kind_t      kind,
  input  logic             is_user,
  input  logic             is_store,
  input  logic             is_fetch,
  input  logic             nxe,
  input  logic             smep,
  output logic [ERR_W-1:0] code
);
  always_comb begin
    code = '0;
    if (kind != FK_NONE) begin
      unique case (kind)
        FK_RSVD: code[EB_R] = 1'b1;
        FK_PROT: code[EB_P] = 1'b1;
        FK_KEY:  begin code[EB_P] = 1'b1; code[EB_K] = 1'b1; end
        default: ;
      endcase
      code[EB_U] = is_user;
      code[EB_W] = is_store;
      code[EB_I] = is_fetch && (nxe || smep);
    end
  end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
  import pgperm_pkg::*;
#(
  parameter int KEY_W = 4,
  parameter int PKR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       acc_type,
  input  logic [1:0]       priv_lvl,
  input  logic             flag_nx,
  input  logic             flag_user,
  input  logic             flag_wr,
  input  logic [KEY_W-1:0] pte_key,
  input  logic             mode_wp,
  input  logic             mode_smep,
  input  logic             mode_nxe,
  input  logic             mode_pke,
  input  logic             mode_pks,
  input  logic [PKR_W-1:0] ukey_reg,
  input  logic [PKR_W-1:0] skey_reg,
  input  logic             walk_np,
  input  logic             walk_rsvd,
  output logic             rsp_valid,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic             acc_ok,
  output logic [ERR_W-1:0] err_code
);
  logic        is_user, no_user_pg, is_store, is_fetch;
  logic [1:0]  acc_idx;
  logic [2:0]  base_prot, key_prot, eff_prot, out_prot;
  fault_kind_t kind;
  logic [ERR_W-1:0] code_nx;

  always_comb begin
    is_user    = (priv_lvl == PRIV_USER);
    no_user_pg = (priv_lvl == PRIV_SUP_NU);
    is_store   = (acc_type == ACC_STORE);
    is_fetch   = (acc_type == ACC_FETCH);
    acc_idx    = is_fetch ? 2'd2 : (is_store ? 2'd1 : 2'd0);
  end

  pgperm_rights u_rights (
    .is_user   (is_user),
    .no_user_pg(no_user_pg),
    .flag_nx   (flag_nx),
    .flag_user (flag_user),
    .flag_wr   (flag_wr),
    .wp        (mode_wp),
    .smep      (mode_smep),
    .prot      (base_prot)
  );

  pgperm_keyfilt #(.KEY_W(KEY_W), .PKR_W(PKR_W)) u_key (
    .is_user  (is_user),
    .wp       (mode_wp),
    .pke      (mode_pke),
    .pks      (mode_pks),
    .flag_user(flag_user),
    .key      (pte_key),
    .ukey     (ukey_reg),
    .skey     (skey_reg),
    .kprot    (key_prot)
  );

  always_comb begin
    eff_prot = base_prot & key_prot;
    out_prot = eff_prot;
    if (walk_np) begin
      kind = FK_NOTPRES;   out_prot = '0;
    end else if (walk_rsvd) begin
      kind = FK_RSVD;      out_prot = '0;
    end else if (is_user && !flag_user) begin
      kind = FK_PROT;      out_prot = '0;
    end else if (!key_prot[acc_idx]) begin
      kind = FK_KEY;
    end else if (!eff_prot[acc_idx]) begin
      kind = FK_PROT;
    end else begin
      kind = FK_NONE;
    end
  end

  pgperm_ecode u_ecode (
    .kind    (kind),
    .is_user (is_user),
    .is_store(is_store),
    .is_fetch(is_fetch),
    .nxe     (mode_nxe),
    .smep    (mode_smep),
    .code    (code_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      perm_r    <= 1'b0;
      perm_w    <= 1'b0;
      perm_x    <= 1'b0;
      acc_ok    <= 1'b0;
      err_code  <= '0;
    end else begin
      rsp_valid <= req_valid;
      perm_r    <= out_prot[0];
      perm_w    <= out_prot[1];
      perm_x    <= out_prot[2];
      acc_ok    <= (kind == FK_NONE);
      err_code  <= code_nx;
    end
  end
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] acc_type,
  input logic [1:0] priv_lvl,
  input logic       flag_user,
  input logic       rsp_valid,
  input logic       perm_r,
  input logic       perm_w,
  input logic       perm_x,
  input logic       acc_ok,
  input logic [5:0] err_code
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1

  AST_USER_SUP_PAGE: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv_lvl == 2'd0 && !flag_user |=> !acc_ok && !perm_r && !perm_w && !perm_x); // R2

  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!perm_w || perm_r)); // R3

  AST_KEY_HAS_PRESENT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && err_code[5] |-> err_code[0]); // R7

  AST_FETCH_NO_KEY: assert property (@(posedge clk) disable iff (rst)
    req_valid && acc_type == 2'd2 |=> !err_code[5]); // R6

  AST_USER_BIT: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv_lvl != 2'd0 |=> !err_code[2]); // R9

  AST_OK_SELECTS_PERM: assert property (@(posedge clk) disable iff (rst)
    req_valid && acc_type == 2'd1 |=> acc_ok == perm_w); // R10

  AST_OK_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && acc_ok |-> err_code == 6'd0); // R10
endmodule

bind pgperm_check pgperm_check_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .acc_type (acc_type),
  .priv_lvl (priv_lvl),
  .flag_user(flag_user),
  .rsp_valid(rsp_valid),
  .perm_r   (perm_r),
  .perm_w   (perm_w),
  .perm_x   (perm_x),
  .acc_ok   (acc_ok),
  .err_code (err_code)
);

// File: tb/sim_pgperm_check.sv
`timescale 1ns/1ps
module sim_pgperm_check;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] acc_type = '0, priv_lvl = '0;
  logic flag_nx = 1'b0, flag_user = 1'b0, flag_wr = 1'b0;
  logic [3:0] pte_key = '0;
  logic mode_wp = 1'b0, mode_smep = 1'b0, mode_nxe = 1'b0, mode_pke = 1'b0, mode_pks = 1'b0;
  logic [31:0] ukey_reg = '0, skey_reg = '0;
  logic walk_np = 1'b0, walk_rsvd = 1'b0;
  logic rsp_valid, perm_r, perm_w, perm_x, acc_ok;
  logic [5:0] err_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pgperm_check u0 (.*);

  // behavioural model: returns {perm[2:0], ok, code[5:0]}
  function automatic int model();
    int user, r, w, x, pkr, k, kr, ok, code, reason, perm, a;
    user = (priv_lvl == 0);
    a = acc_type;
    r = !(priv_lvl == 2 && flag_user);
    w = r && (flag_wr || (!user && !mode_wp));
    x = !flag_nx && (user || !mode_smep || !flag_user);
    perm = r | (w << 1) | (x << 2);
    pkr = 0;
    if (flag_user && mode_pke) pkr = ukey_reg;
    if (!flag_user && mode_pks) pkr = skey_reg;
    kr = 7;
    if (pkr != 0) begin
      k = pte_key;
      if ((pkr >> (2*k)) & 1) kr = 4;
      else if (((pkr >> (2*k+1)) & 1) && (user || mode_wp)) kr = 5;
    end
    perm = perm & kr;
    reason = 0; // 0 ok,1 np,2 rsvd,3 prot,4 key
    if (walk_np) reason = 1;
    else if (walk_rsvd) reason = 2;
    else if (user && !flag_user) reason = 3;
    else if (((kr >> a) & 1) == 0) reason = 4;
    else if (((perm >> a) & 1) == 0) reason = 3;
    if (reason == 1 || reason == 2 || (reason == 3 && user && !flag_user)) perm = 0;
    ok = (reason == 0);
    code = 0;
    if (!ok) begin
      if (reason == 2) code = 8;
      if (reason == 3) code = 1;
      if (reason == 4) code = 33;
      if (user) code += 4;
      if (a == 1) code += 2;
      if (a == 2 && (mode_nxe || mode_smep)) code += 16;
    end
    return (perm << 7) | (ok << 6) | code;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, response checked at the following negedge
  task automatic step(string tag);
    int e;
    req_valid = 1'b1;
    e = model();
    @(negedge clk);
    cmp({tag, " valid R1"}, rsp_valid, 1);
    cmp({tag, " perms"}, {perm_x, perm_w, perm_r}, (e >> 7) & 7);
    cmp({tag, " ok R10"}, acc_ok, (e >> 6) & 1);
    cmp({tag, " code"}, err_code, e & 63);
  endtask

  task automatic setv(input int a, p, nx, u, wr, k, wp, smep, nxe, pke, pks,
                      input logic [31:0] uk, sk, input int np, rs);
    acc_type = 2'(a); priv_lvl = 2'(p); flag_nx = 1'(nx); flag_user = 1'(u);
    flag_wr = 1'(wr); pte_key = 4'(k); mode_wp = 1'(wp); mode_smep = 1'(smep);
    mode_nxe = 1'(nxe); mode_pke = 1'(pke); mode_pks = 1'(pks);
    ukey_reg = uk; skey_reg = sk; walk_np = 1'(np); walk_rsvd = 1'(rs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 reset valid", rsp_valid, 0);
    cmp("R1 reset code", err_code, 0);
    cmp("R1 reset perms", {perm_x, perm_w, perm_r, acc_ok}, 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 idle valid", rsp_valid, 0);

    // R2: user to supervisor page, expected code 0x05
    setv(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 user->sup load");
    cmp("R2 code", err_code, 6'h05);
    // R3: supervisor write to read-only with WP clear passes, set fails
    setv(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 sup store wp0");
    cmp("R3 ok", acc_ok, 1);
    setv(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 sup store wp1");
    cmp("R3 code", err_code, 6'h03);
    // R3: barred supervisor reading user page
    setv(0, 2, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 no-user sup load");
    cmp("R3 barred", acc_ok, 0);
    // R4: smep blocks supervisor fetch from user page, code 0x11
    setv(2, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R4 smep fetch");
    cmp("R4 code", err_code, 6'h11);
    setv(2, 0, 1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R4 nx user fetch");
    cmp("R4 nx code", err_code, 6'h15);
    // R5/R6/R7: user key 3 access-disable (bit 6) on load, code 0x25
    setv(0, 0, 0, 1, 1, 3, 0, 0, 0, 1, 0, 32'h40, 0, 0, 0);
    step("R6 key ad load");
    cmp("R7 key code", err_code, 6'h25);
    // R5: PKE off ignores the register
    setv(0, 0, 0, 1, 1, 3, 0, 0, 0, 0, 0, 32'h40, 0, 0, 0);
    step("R5 pke off");
    cmp("R5 ok", acc_ok, 1);
    // R5: supervisor page uses skey, key 1 write-disable (bit 3), wp=1
    setv(1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 32'h8, 0, 0);
    step("R5 pks wd store");
    cmp("R7 sup key code", err_code, 6'h23);
    // R6: write-disable ignored for supervisor with wp=0
    setv(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, 32'h8, 0, 0);
    step("R6 wd wp0");
    cmp("R6 ok", acc_ok, 1);
    // R6: access-disable never blocks fetch
    setv(2, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, 32'h1, 0, 0, 0);
    step("R6 ad fetch");
    cmp("R6 fetch ok", acc_ok, 1);
    // R8: not-present priority, store by user, code 0x06
    setv(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R8 np");
    cmp("R8 np code", err_code, 6'h06);
    setv(0, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8 rsvd");
    cmp("R8 rsvd code", err_code, 6'h08);
    // R9: fetch fault without nxe/smep leaves bit 4 clear
    setv(2, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 fetch noflag");
    cmp("R9 code", err_code, 6'h01);

    // R10: broad patterns
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] uk, sk;
      uk = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      sk = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      setv($urandom % 3, $urandom % 3, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 16, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, uk, sk, ($urandom % 8 == 0), ($urandom % 8 == 0));
      step("R10 random");
    end
    req_valid = 1'b0;
    @(negedge clk);
    cmp("R1 drop valid", rsp_valid, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule